// File: doc/BRIEF.md
# Quad-capable SPI master shift engine

This block is the serial engine of a SPI master that can also move data over four IO lines at once. A host writes bytes through a data-register write strobe and reads received bytes through a read strobe. A transmit-buffer-empty flag and a receive-buffer-not-empty flag show how far the host and the engine have progressed. The engine drives SCK and, for each of four IO lanes, a data-out and an output-enable signal. Lane 0 is MOSI, lane 1 is MISO, and lanes 2 and 3 are the extra quad lines.

There are three operating modes. Standard mode is full duplex, one bit per SCK period. Quad write sends one nibble per SCK period on all four lanes. In quad read, all four lanes are inputs, and a write to the data register only supplies SCK pulses for one byte. At the end of each byte the engine continues only if the enable bit is still set and the host has written another byte. The host can therefore stream data by writing the next byte as soon as the transmit-buffer-empty flag returns.

Clock polarity is a parameter. SCK runs at half the system clock rate. Data changes on the edge that leaves the idle level, and inputs are captured on the edge that returns to it.

Top module: `qspi_shift_engine`

## Requirements
- R1: After reset, SCK sits at the idle level CPOL, the transmit-buffer-empty flag is 1, the receive flag is 0, and all output enables are 0.
- R2: Output enables follow the mode. Enable low gives 4'b0000. Enable high with quad off gives 4'b0001 (only MOSI driven). Enable, quad and quad-read all high give 4'b0000. Enable and quad high with quad-read low give 4'b1111. During a byte, the mode captured at its start applies.
- R3: A data write clears the transmit-buffer-empty flag on the next cycle. If enable is high and the engine is idle, clocking starts on the following cycle. SCK is then at the active level (not CPOL) for exactly one system clock in each two-cycle period, and rests at CPOL whenever no byte is in flight.
- R4: The flag returns to 1 in the cycle the written byte enters the shifter. A byte written during a frame starts in the period directly after the last period of that frame, with no idle cycle between them. With nothing pending, clocking stops after the frame.
- R5: Quad write uses two SCK periods per byte. Bits 7..4 go first, then bits 3..0. Within a nibble, bit 0 (or 4) is on lane 0, bit 1 (or 5) on lane 1, bit 2 (or 6) on lane 2, and bit 3 (or 7) on lane 3.
- R6: Standard mode uses eight SCK periods per byte. It sends the MSB first on lane 0 and captures lane 1, MSB first, into the received byte.
- R7: In quad read, the written value has no effect. All lanes are inputs. Each byte is assembled from two captured nibbles, the first becoming bits 7..4, using the lane-to-bit mapping of R5.
- R8: At the end of a byte in standard or quad-read mode, the received byte appears on the read-data output and the receive flag goes to 1. A quad-write byte leaves both unchanged. A read strobe clears the flag, unless a new byte completes in the same cycle, in which case the flag stays set.
- R9: A pending byte with enable low produces no SCK activity. Clearing enable during a byte lets that byte finish, and no further byte starts.
- R10: Any lane whose output enable is 0 has its data-out held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Engine enable |
| quad_mode_i | input | 1 | Selects four-lane operation |
| quad_read_i | input | 1 | With quad mode, all lanes become inputs |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Byte to send (a dummy byte in quad read) |
| data_re_i | input | 1 | Data register read strobe, clears the receive flag |
| rx_data_o | output | 8 | Last received byte |
| tbe_o | output | 1 | Transmit buffer empty |
| rbne_o | output | 1 | Receive buffer not empty |
| sck_o | output | 1 | Serial clock |
| io_do_o | output | 4 | Lane data out (lane 0 = MOSI, 1 = MISO, 2, 3) |
| io_oe_o | output | 4 | Lane output enables |
| io_di_i | input | 4 | Lane data in |

## Verification
The assertions assume the mode inputs do not change while a byte is in flight, apart from enable being cleared. They also assume the host writes only while the transmit-buffer-empty flag is 1, so a pending byte is never overwritten. The stimulus changes the mode bits only after SCK has been idle for several cycles. It polls the flag before every write, and it only drops enable mid-frame when it is deliberately exercising the stop condition.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_QWR = 2'd1,
    MODE_QRD = 2'd2,
    MODE_OFF = 2'd3
  } qspi_mode_e;

  function automatic qspi_mode_e decode_mode(logic en, logic qm, logic qr);
    if (!en) return MODE_OFF;
    if (!qm) return MODE_STD;
    return qr ? MODE_QRD : MODE_QWR;
  endfunction
endpackage

// File: rtl/qspi_txbuf.sv
module qspi_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              tbe_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbe_o  <= 1'b1;
      data_o <= '0;
    end else if (we_i) begin
      tbe_o  <= 1'b0;
      data_o <= wdata_i;
    end else if (take_i) begin
      tbe_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter int   LANES  = 4,
  parameter logic CPOL   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       pending_i,
  input  qspi_mode_e live_mode_i,
  output logic       load_o,
  output logic       sample_o,
  output logic       shift_o,
  output logic       frame_done_o,
  output logic       active_o,
  output qspi_mode_e mode_q_o,
  output logic       sck_o
);
  localparam int CNT_W     = $clog2(DATA_W);
  localparam int STD_LAST  = DATA_W - 1;
  localparam int QUAD_LAST = DATA_W / LANES - 1;

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_period;
  logic             end_period;

  assign last_period  = (mode_q_o == MODE_STD) ? (cnt_q == CNT_W'(STD_LAST))
                                               : (cnt_q == CNT_W'(QUAD_LAST));
  assign sample_o     = active_o & ~phase_q;
  assign end_period   = active_o & phase_q;
  assign frame_done_o = end_period & last_period;
  assign shift_o      = end_period & ~last_period;
  // byte boundary check: continue only with enable and a pending write
  assign load_o       = enable_i & pending_i & (~active_o | frame_done_o);
  assign sck_o        = sample_o ? ~CPOL : CPOL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      mode_q_o <= MODE_STD;
    end else if (load_o) begin
      active_o <= 1'b1;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      mode_q_o <= live_mode_i;
    end else if (frame_done_o) begin
      active_o <= 1'b0;
      phase_q  <= 1'b0;
    end else if (active_o) begin
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qspi_datapath.sv
module qspi_datapath
  import qspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] txdata_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              frame_done_i,
  input  logic              read_i,
  input  qspi_mode_e        mode_q_i,
  input  logic [LANES-1:0]  io_di_i,
  output logic [LANES-1:0]  tx_lanes_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rbne_o
);
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              is_std;

  assign is_std = (mode_q_i == MODE_STD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
    end else if (load_i) begin
      tx_sh <= txdata_i;
    end else if (shift_i) begin
      tx_sh <= is_std ? (tx_sh << 1) : (tx_sh << LANES);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh <= '0;
    end else if (sample_i) begin
      rx_sh <= is_std ? {rx_sh[DATA_W-2:0], io_di_i[1]}
                      : {rx_sh[DATA_W-LANES-1:0], io_di_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rbne_o    <= 1'b0;
    end else if (frame_done_i && mode_q_i != MODE_QWR) begin
      rx_data_o <= rx_sh;
      rbne_o    <= 1'b1;
    end else if (read_i) begin
      rbne_o    <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_mosi
      assign tx_lanes_o[g] = is_std ? tx_sh[DATA_W-1] : tx_sh[DATA_W-LANES+g];
    end else begin : g_aux
      assign tx_lanes_o[g] = is_std ? 1'b0 : tx_sh[DATA_W-LANES+g];
    end
  end
endmodule

// File: rtl/qspi_shift_engine.sv
module qspi_shift_engine
  import qspi_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter int   LANES  = 4,
  parameter logic CPOL   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              quad_mode_i,
  input  logic              quad_read_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              data_re_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tbe_o,
  output logic              rbne_o,
  output logic              sck_o,
  output logic [LANES-1:0]  io_do_o,
  output logic [LANES-1:0]  io_oe_o,
  input  logic [LANES-1:0]  io_di_i
);
  qspi_mode_e        live_mode, mode_q, oe_mode;
  logic              load, sample, shift, frame_done, active;
  logic [DATA_W-1:0] buf_data;
  logic [LANES-1:0]  tx_lanes;

  assign live_mode = decode_mode(enable_i, quad_mode_i, quad_read_i);
  assign oe_mode   = active ? mode_q : live_mode;

  always_comb begin
    unique case (oe_mode)
      MODE_STD: io_oe_o = LANES'(1);
      MODE_QWR: io_oe_o = '1;
      default:  io_oe_o = '0;
    endcase
  end

  assign io_do_o = tx_lanes & io_oe_o;

  qspi_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we_i),
    .wdata_i (data_wdata_i),
    .take_i  (load),
    .tbe_o   (tbe_o),
    .data_o  (buf_data)
  );

  qspi_seq #(.DATA_W(DATA_W), .LANES(LANES), .CPOL(CPOL)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .pending_i    (~tbe_o),
    .live_mode_i  (live_mode),
    .load_o       (load),
    .sample_o     (sample),
    .shift_o      (shift),
    .frame_done_o (frame_done),
    .active_o     (active),
    .mode_q_o     (mode_q),
    .sck_o        (sck_o)
  );

  qspi_datapath #(.DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .txdata_i     (buf_data),
    .sample_i     (sample),
    .shift_i      (shift),
    .frame_done_i (frame_done),
    .read_i       (data_re_i),
    .mode_q_i     (mode_q),
    .io_di_i      (io_di_i),
    .tx_lanes_o   (tx_lanes),
    .rx_data_o    (rx_data_o),
    .rbne_o       (rbne_o)
  );
endmodule

// File: rtl/qspi_shift_engine_checker.sv
module qspi_shift_engine_checker #(
  parameter int   LANES = 4,
  parameter logic CPOL  = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             quad_mode_i,
  input logic             quad_read_i,
  input logic             data_we_i,
  input logic             data_re_i,
  input logic             tbe_o,
  input logic             rbne_o,
  input logic             sck_o,
  input logic [LANES-1:0] io_do_o,
  input logic [LANES-1:0] io_oe_o,
  input logic             active,
  input logic             frame_done
);
  assert_write_clears_tbe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> !tbe_o);

  assert_sck_half_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != CPOL) |=> (sck_o == CPOL));

  assert_qrd_lanes_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && enable_i && quad_mode_i && quad_read_i) |-> (io_oe_o == '0));

  assert_undriven_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((io_do_o & ~io_oe_o) == '0));

  assert_read_clears_rbne_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && !frame_done) |=> !rbne_o);

  assert_disabled_no_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !enable_i) |=> (sck_o == CPOL));
endmodule

bind qspi_shift_engine qspi_shift_engine_checker #(.LANES(LANES), .CPOL(CPOL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .quad_mode_i (quad_mode_i),
  .quad_read_i (quad_read_i),
  .data_we_i   (data_we_i),
  .data_re_i   (data_re_i),
  .tbe_o       (tbe_o),
  .rbne_o      (rbne_o),
  .sck_o       (sck_o),
  .io_do_o     (io_do_o),
  .io_oe_o     (io_oe_o),
  .active      (active),
  .frame_done  (frame_done)
);

// File: tb/qspi_shift_engine_bench.sv
`timescale 1ns/1ps
module qspi_shift_engine_bench;
  localparam logic CPOL = 1'b0;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 0, quad_mode_i = 0, quad_read_i = 0;
  logic       data_we_i = 0, data_re_i = 0;
  logic [7:0] data_wdata_i = 0;
  logic [3:0] io_di_i = 0;
  logic [7:0] rx_data_o;
  logic       tbe_o, rbne_o, sck_o;
  logic [3:0] io_do_o, io_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  qspi_shift_engine u_qspi_shift_engine (.*);

  // behavioural model; modes: 0 std, 1 quad write, 2 quad read, 3 off
  int   m_act, m_ph, m_cnt, m_mode;
  logic [7:0] m_tx, m_rx, m_rxd, m_buf;
  bit   m_tbe, m_rbne;

  function automatic int live_mode();
    if (!enable_i) return 3;
    if (!quad_mode_i) return 0;
    return quad_read_i ? 2 : 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int lm = live_mode();
    bit last = (m_mode == 0) ? (m_cnt == 7) : (m_cnt == 1);
    bit smp = m_act && m_ph == 0;
    bit endp = m_act && m_ph == 1;
    bit fdone = endp && last;
    bit shf = endp && !last;
    bit ld = enable_i && !m_tbe && (!m_act || fdone);
    logic [7:0] old_rx = m_rx;
    if (smp) m_rx = (m_mode == 0) ? {m_rx[6:0], io_di_i[1]} : {m_rx[3:0], io_di_i};
    if (fdone && m_mode != 1) begin m_rxd = old_rx; m_rbne = 1; end
    else if (data_re_i) m_rbne = 0;
    if (ld) m_tx = m_buf;
    else if (shf) m_tx = (m_mode == 0) ? (m_tx << 1) : (m_tx << 4);
    if (data_we_i) begin m_buf = data_wdata_i; m_tbe = 0; end
    else if (ld) m_tbe = 1;
    if (ld) begin m_act = 1; m_ph = 0; m_cnt = 0; m_mode = lm; end
    else if (fdone) begin m_act = 0; m_ph = 0; end
    else if (m_act) begin if (m_ph) m_cnt++; m_ph = !m_ph; end
  endtask

  task automatic compare();
    int om = m_act ? m_mode : live_mode();
    logic [3:0] eoe = (om == 0) ? 4'b0001 : (om == 1) ? 4'b1111 : 4'b0000;
    logic [3:0] raw = (m_mode == 0) ? {3'b000, m_tx[7]} : m_tx[7:4];
    logic esck = (m_act && m_ph == 0) ? ~CPOL : CPOL;
    chk(sck_o == esck, "R3 sck", sck_o, esck);
    chk(tbe_o == m_tbe, "R4 tbe", tbe_o, m_tbe);
    chk(rbne_o == m_rbne, "R8 rbne", rbne_o, m_rbne);
    chk(rx_data_o == m_rxd, "R6/R7 rx_data", rx_data_o, m_rxd);
    chk(io_oe_o == eoe, "R2 io_oe", io_oe_o, eoe);
    chk(io_do_o == (raw & eoe), "R5 io_do", io_do_o, raw & eoe);
  endtask

  // one system clock: inputs already applied, step model, then compare at negedge
  task automatic tick();
    io_di_i = io_di_i + 4'd5;
    model_step();
    @(negedge clk_i);
    compare();
    data_we_i = 0;
    data_re_i = 0;
  endtask

  task automatic write_byte(logic [7:0] b);
    while (!tbe_o) tick();
    data_we_i = 1; data_wdata_i = b;
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic read_rx();
    data_re_i = 1;
    tick();
  endtask

  initial begin
    int sck_edges;
    logic [7:0] qrd_a, qrd_b;
    m_act = 0; m_ph = 0; m_cnt = 0; m_mode = 0;
    m_tx = 0; m_rx = 0; m_rxd = 0; m_buf = 0; m_tbe = 1; m_rbne = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(sck_o == CPOL, "R1 sck idle", sck_o, CPOL);
    chk(tbe_o == 1, "R1 tbe", tbe_o, 1);
    chk(rbne_o == 0, "R1 rbne", rbne_o, 0);
    chk(io_oe_o == 0, "R1 oe", io_oe_o, 0);
    rst_ni = 1;
    idle(2);

    // R9: pending byte with enable low never clocks
    data_we_i = 1; data_wdata_i = 8'h5A; tick();
    sck_edges = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (sck_o != CPOL) sck_edges++; end
    chk(sck_edges == 0, "R9 no sck when disabled", sck_edges, 0);

    // R6 standard mode, pending byte starts on enable, back-to-back
    enable_i = 1; tick();
    chk(tbe_o == 1, "R4 tbe back after load", tbe_o, 1);
    write_byte(8'hC3);
    idle(40);
    chk(rbne_o == 1, "R8 rbne after std byte", rbne_o, 1);
    read_rx();
    chk(rbne_o == 0, "R8 read clears", rbne_o, 0);
    write_byte(8'hA5);
    idle(20);
    read_rx();

    // R5 quad write: two periods per byte, no receive flag
    quad_mode_i = 1; idle(3);
    chk(io_oe_o == 4'hF, "R2 quad write oe", io_oe_o, 4'hF);
    write_byte(8'h3C); write_byte(8'h96); write_byte(8'h0F);
    idle(12);
    chk(rbne_o == 0, "R8 no rbne in quad write", rbne_o, 0);

    // R7 quad read: dummy value ignored, same lane pattern gives same data
    quad_read_i = 1; idle(3);
    chk(io_oe_o == 4'h0, "R2 quad read oe", io_oe_o, 4'h0);
    io_di_i = 4'h0;
    write_byte(8'hFF); idle(8); qrd_a = rx_data_o; read_rx();
    io_di_i = 4'h0;
    write_byte(8'h00); idle(8); qrd_b = rx_data_o;
    chk(qrd_a == qrd_b, "R7 dummy ignored", qrd_b, qrd_a);
    chk(io_do_o == 0, "R10 undriven lanes low", io_do_o, 0);
    // R8 read strobe on completion cycle: keep reading each cycle of a frame
    write_byte(8'h11);
    for (int i = 0; i < 6; i++) begin data_re_i = 1; tick(); end
    idle(4);

    // R9: enable dropped mid-frame, pending byte not started
    quad_read_i = 0; quad_mode_i = 0; idle(3);
    write_byte(8'h81); write_byte(8'h7E);
    idle(3); enable_i = 0;
    sck_edges = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (sck_o != CPOL) sck_edges++; end
    chk(tbe_o == 0, "R9 pending byte kept", tbe_o, 0);
    chk(sck_edges <= 8, "R9 frame finishes then stops", sck_edges, 8);
    idle(4);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule